// File: doc/BRIEF.md
# Interrupt Source Delivery Router

This block sits between the interrupt sources of a multiprocessor interrupt controller and its per-CPU presentation units. For every source it keeps a small configuration and state record: a pending flag, a mask bit, a 4-bit priority, an in-service (activity) bit, a delivery-mode bit, a destination bitmask with one bit per CPU, and the index of the CPU that last received the source. When the surrounding logic asks for a source to be re-evaluated, the router decides in one cycle whether the source may be forwarded and to which CPU or CPUs. On the following cycle it raises a one-cycle deliver strobe toward each chosen CPU, together with the source number.

Configuration and the pending level come in through a plain write port. Activity is set when a presentation unit accepts a delivered source. It is cleared by a per-source end-of-interrupt strobe. Eligibility is tested in a fixed order, and the checks come before any routing. There are two routing styles. In broadcast-to-mask mode the source goes to every CPU whose mask bit is set. In rotating mode only one CPU is served: the block searches round-robin, starting just after the CPU that was served last.

Top module: `irq_route_top`

## Requirements
- R1: After reset every source is masked, has priority zero, is not pending and not active, and has a last-served index of 0. `dlv_valid` is low.
- R2: An evaluation requested with `eval_req` high at a clock edge drives `dlv_valid` on the next cycle for exactly one cycle. When any bit is set, `dlv_src` holds the evaluated source index.
- R3: A source whose pending flag is clear is not delivered.
- R4: A source whose mask bit is 1 is not delivered.
- R5: A source whose priority is 0 is never delivered.
- R6: A source whose activity bit is set is not delivered. `acc_valid` sets the activity bit of `acc_sel`, and `eoi_clr[i]` clears the bit of source i. If both hit the same source in one cycle, the bit ends up set.
- R7: A source whose destination mask is all zeros is not delivered.
- R8: If the destination mask equals exactly the bit of the last-served CPU, only that CPU is served, whatever the mode, and the last-served index is unchanged.
- R9: With the mode bit at 0, every CPU whose destination bit is set is served in the same strobe. Bit i of `cfg_dest` and of `dlv_valid` both mean CPU i.
- R10: With the mode bit at 1, the search starts at last-served+1, wraps to 0 at `NUM_CPU`, and serves only the first CPU whose mask bit is set. That CPU becomes the new last-served index.
- R11: Each source keeps its own last-served index. Rotating deliveries of one source do not move another source's index.
- R12: An evaluation uses the state as it stood before the same cycle's configuration, pending, accept and end-of-interrupt writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for source configuration |
| cfg_sel | input | SRC_W | Source being configured |
| cfg_mask | input | 1 | Mask bit (1 = blocked) |
| cfg_prio | input | 4 | Priority, 0 = never delivered |
| cfg_mode | input | 1 | 0 = serve every masked-in CPU, 1 = rotate over them |
| cfg_dest | input | NUM_CPU | Destination CPU bitmask |
| pend_we | input | 1 | Write enable for a pending flag |
| pend_sel | input | SRC_W | Source whose pending flag is written |
| pend_val | input | 1 | New pending level |
| eval_req | input | 1 | Re-evaluate a source this cycle |
| eval_sel | input | SRC_W | Source to evaluate |
| acc_valid | input | 1 | A presentation unit accepted a source |
| acc_sel | input | SRC_W | Accepted source, its activity bit is set |
| eoi_clr | input | NUM_SRC | Per-source end-of-interrupt clear strobes |
| dlv_valid | output | NUM_CPU | One-cycle deliver strobe per CPU |
| dlv_src | output | SRC_W | Source number carried with the strobe |

## Verification
Setting and clearing the activity bit can land on the same source in the same clock: one presentation unit accepts a source while the end-of-interrupt for its previous occurrence arrives. The bench pulses `acc_valid` and `eoi_clr` for one source in one cycle and then evaluates that source. No delivery must follow, because the set wins. A lone end-of-interrupt afterwards must let the source through again. A configuration write that coincides with an evaluation of the same source is also exercised: the strobe must follow the old configuration, and a second evaluation must follow the new one.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int PRIO_W = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        RT_NONE,
        RT_SOLE,
        RT_DIRECT,
        RT_ROTATE
    } route_kind_e;

endpackage

// File: rtl/irq_rr_pick.sv
// Round-robin picker: first set request strictly after 'after', wrapping.
module irq_rr_pick #(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [NUM_CPU-1:0] req,
    input  logic [CPU_W-1:0]   after,
    output logic               found,
    output logic [CPU_W-1:0]   pick
);

    localparam logic [CPU_W:0] NCPU_V = (CPU_W + 1)'(NUM_CPU);

    logic [CPU_W:0]   sum;
    logic [CPU_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        sum   = '0;
        idx   = '0;
        for (int k = 1; k <= NUM_CPU; k++) begin
            sum = {1'b0, after} + (CPU_W + 1)'(k);
            if (sum >= NCPU_V) begin
                sum = sum - NCPU_V;
            end
            idx = sum[CPU_W-1:0];
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

endmodule

// File: rtl/irq_route_decide.sv
// Eligibility gating in fixed order, then target selection.
module irq_route_decide
    import irq_route_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               pend,
    input  logic               mask,
    input  prio_t              prio,
    input  logic               act,
    input  logic               mode,
    input  logic [NUM_CPU-1:0] dest,
    input  logic [CPU_W-1:0]   last,
    output logic [NUM_CPU-1:0] hit,
    output logic               upd,
    output logic [CPU_W-1:0]   new_last
);

    route_kind_e        kind;
    logic               eligible;
    logic [NUM_CPU-1:0] sole_bit;
    logic               rr_found;
    logic [CPU_W-1:0]   rr_pick;

    irq_rr_pick #(.NUM_CPU(NUM_CPU)) u_pick (
        .req   (dest),
        .after (last),
        .found (rr_found),
        .pick  (rr_pick)
    );

    always_comb begin
        sole_bit = NUM_CPU'(1) << last;
        eligible = pend && !mask && (prio != '0) && !act && (dest != '0);

        kind = RT_NONE;
        if (eligible) begin
            if (dest == sole_bit) begin
                kind = RT_SOLE;
            end else if (!mode) begin
                kind = RT_DIRECT;
            end else begin
                kind = RT_ROTATE;
            end
        end

        hit      = '0;
        upd      = 1'b0;
        new_last = rr_pick;
        case (kind)
            RT_SOLE:   hit = sole_bit;
            RT_DIRECT: hit = dest;
            RT_ROTATE: begin
                if (rr_found) begin
                    hit = NUM_CPU'(1) << rr_pick;
                    upd = 1'b1;
                end
            end
            default:   hit = '0;
        endcase
    end

endmodule

// File: rtl/irq_src_state.sv
// Per-source configuration and state table.
module irq_src_state
    import irq_route_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int NUM_CPU = 4,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [SRC_W-1:0]                cfg_sel,
    input  logic                            cfg_mask,
    input  prio_t                           cfg_prio,
    input  logic                            cfg_mode,
    input  logic [NUM_CPU-1:0]              cfg_dest,
    input  logic                            pend_we,
    input  logic [SRC_W-1:0]                pend_sel,
    input  logic                            pend_val,
    input  logic                            acc_valid,
    input  logic [SRC_W-1:0]                acc_sel,
    input  logic [NUM_SRC-1:0]              eoi_clr,
    input  logic                            last_we,
    input  logic [SRC_W-1:0]                last_sel,
    input  logic [CPU_W-1:0]                last_val,
    output logic [NUM_SRC-1:0]              pend_o,
    output logic [NUM_SRC-1:0]              mask_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NUM_SRC-1:0]              mode_o,
    output logic [NUM_SRC-1:0]              act_o,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0] dest_o,
    output logic [NUM_SRC-1:0][CPU_W-1:0]   last_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]              pend;
        logic [NUM_SRC-1:0]              mask;
        logic [NUM_SRC-1:0]              mode;
        logic [NUM_SRC-1:0]              act;
        logic [NUM_SRC-1:0][PRIO_W-1:0]  prio;
        logic [NUM_SRC-1:0][NUM_CPU-1:0] dest;
        logic [NUM_SRC-1:0][CPU_W-1:0]   last;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we) begin
            tbl_d.mask[cfg_sel] = cfg_mask;
            tbl_d.prio[cfg_sel] = cfg_prio;
            tbl_d.mode[cfg_sel] = cfg_mode;
            tbl_d.dest[cfg_sel] = cfg_dest;
        end
        if (pend_we) begin
            tbl_d.pend[pend_sel] = pend_val;
        end
        tbl_d.act = tbl_d.act & ~eoi_clr;
        if (acc_valid) begin
            tbl_d.act[acc_sel] = 1'b1;
        end
        if (last_we) begin
            tbl_d.last[last_sel] = last_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q      <= '0;
            tbl_q.mask <= '1;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign pend_o = tbl_q.pend;
    assign mask_o = tbl_q.mask;
    assign prio_o = tbl_q.prio;
    assign mode_o = tbl_q.mode;
    assign act_o  = tbl_q.act;
    assign dest_o = tbl_q.dest;
    assign last_o = tbl_q.last;

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int NUM_CPU = 4,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_sel,
    input  logic               cfg_mask,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cfg_mode,
    input  logic [NUM_CPU-1:0] cfg_dest,
    input  logic               pend_we,
    input  logic [SRC_W-1:0]   pend_sel,
    input  logic               pend_val,
    input  logic               eval_req,
    input  logic [SRC_W-1:0]   eval_sel,
    input  logic               acc_valid,
    input  logic [SRC_W-1:0]   acc_sel,
    input  logic [NUM_SRC-1:0] eoi_clr,
    output logic [NUM_CPU-1:0] dlv_valid,
    output logic [SRC_W-1:0]   dlv_src
);

    typedef struct packed {
        logic [NUM_CPU-1:0] dlv;
        logic [SRC_W-1:0]   src;
    } out_t;

    logic [NUM_SRC-1:0]              st_pend, st_mask, st_mode, st_act;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  st_prio;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] st_dest;
    logic [NUM_SRC-1:0][CPU_W-1:0]   st_last;

    logic [NUM_CPU-1:0] hit;
    logic               upd;
    logic [CPU_W-1:0]   new_last;
    logic               last_we;

    out_t out_d, out_q;

    assign last_we = eval_req && upd;

    irq_src_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_mask  (cfg_mask),
        .cfg_prio  (cfg_prio),
        .cfg_mode  (cfg_mode),
        .cfg_dest  (cfg_dest),
        .pend_we   (pend_we),
        .pend_sel  (pend_sel),
        .pend_val  (pend_val),
        .acc_valid (acc_valid),
        .acc_sel   (acc_sel),
        .eoi_clr   (eoi_clr),
        .last_we   (last_we),
        .last_sel  (eval_sel),
        .last_val  (new_last),
        .pend_o    (st_pend),
        .mask_o    (st_mask),
        .prio_o    (st_prio),
        .mode_o    (st_mode),
        .act_o     (st_act),
        .dest_o    (st_dest),
        .last_o    (st_last)
    );

    irq_route_decide #(.NUM_CPU(NUM_CPU)) u_decide (
        .pend     (st_pend[eval_sel]),
        .mask     (st_mask[eval_sel]),
        .prio     (st_prio[eval_sel]),
        .act      (st_act[eval_sel]),
        .mode     (st_mode[eval_sel]),
        .dest     (st_dest[eval_sel]),
        .last     (st_last[eval_sel]),
        .hit      (hit),
        .upd      (upd),
        .new_last (new_last)
    );

    always_comb begin
        out_d     = out_q;
        out_d.dlv = '0;
        if (eval_req) begin
            out_d.dlv = hit;
            out_d.src = eval_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dlv_valid = out_q.dlv;
    assign dlv_src   = out_q.src;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int NUM_CPU = 4,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [SRC_W-1:0]   cfg_sel,
    input logic               cfg_mask,
    input logic [PRIO_W-1:0]  cfg_prio,
    input logic [NUM_CPU-1:0] cfg_dest,
    input logic               pend_we,
    input logic [SRC_W-1:0]   pend_sel,
    input logic               pend_val,
    input logic               eval_req,
    input logic [SRC_W-1:0]   eval_sel,
    input logic               acc_valid,
    input logic [SRC_W-1:0]   acc_sel,
    input logic [NUM_CPU-1:0] dlv_valid,
    input logic [SRC_W-1:0]   dlv_src
);

    // R2
    dlv_needs_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dlv_valid) |-> $past(eval_req));

    // R2
    dlv_src_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dlv_valid) |-> (dlv_src == $past(eval_sel)));

    // R3
    not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(pend_we) && !$past(pend_val) && eval_sel == $past(pend_sel))
        |=> (dlv_valid == '0));

    // R4
    masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(cfg_we) && $past(cfg_mask) && eval_sel == $past(cfg_sel))
        |=> (dlv_valid == '0));

    // R5
    zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(cfg_we) && $past(cfg_prio) == '0 && eval_sel == $past(cfg_sel))
        |=> (dlv_valid == '0));

    // R6
    active_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(acc_valid) && eval_sel == $past(acc_sel))
        |=> (dlv_valid == '0));

    // R7
    no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(cfg_we) && $past(cfg_dest) == '0 && eval_sel == $past(cfg_sel))
        |=> (dlv_valid == '0));

endmodule

bind irq_route_top irq_route_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_mask  (cfg_mask),
    .cfg_prio  (cfg_prio),
    .cfg_dest  (cfg_dest),
    .pend_we   (pend_we),
    .pend_sel  (pend_sel),
    .pend_val  (pend_val),
    .eval_req  (eval_req),
    .eval_sel  (eval_sel),
    .acc_valid (acc_valid),
    .acc_sel   (acc_sel),
    .dlv_valid (dlv_valid),
    .dlv_src   (dlv_src)
);

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int NCPU = 4;
    localparam int NVEC = 16;

    // vector fields: mask[14] prio[13:10] mode[9] dest[8:5] pend[4] expect[3:0]
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 4'd5, 1'b0, 4'b1010, 1'b1, 4'b1010},  // R9 broadcast
        {1'b1, 4'd5, 1'b0, 4'b1010, 1'b1, 4'b0000},  // R4 masked
        {1'b0, 4'd0, 1'b0, 4'b1010, 1'b1, 4'b0000},  // R5 prio zero
        {1'b0, 4'd5, 1'b0, 4'b1010, 1'b0, 4'b0000},  // R3 not pending
        {1'b0, 4'd5, 1'b0, 4'b0000, 1'b1, 4'b0000},  // R7 no target
        {1'b0, 4'd5, 1'b1, 4'b1010, 1'b1, 4'b0010},  // R10 last 0 -> 1
        {1'b0, 4'd5, 1'b1, 4'b1010, 1'b1, 4'b1000},  // R10 last 1 -> 3
        {1'b0, 4'd5, 1'b1, 4'b1010, 1'b1, 4'b0010},  // R10 wrap, last 3 -> 1
        {1'b0, 4'd5, 1'b1, 4'b0010, 1'b1, 4'b0010},  // R8 sole, last stays 1
        {1'b0, 4'd5, 1'b0, 4'b0010, 1'b1, 4'b0010},  // R8 sole in mode 0
        {1'b0, 4'd5, 1'b1, 4'b0011, 1'b1, 4'b0001},  // R10 wrap, last 1 -> 0
        {1'b0, 4'd5, 1'b1, 4'b1111, 1'b1, 4'b0010},  // R10 last 0 -> 1
        {1'b0, 4'd5, 1'b0, 4'b1111, 1'b1, 4'b1111},  // R9 all CPUs
        {1'b0, 4'd5, 1'b1, 4'b0001, 1'b1, 4'b0001},  // R10 last 1 -> 0
        {1'b0, 4'd5, 1'b0, 4'b0001, 1'b1, 4'b0001},  // R8 sole
        {1'b0, 4'd5, 1'b1, 4'b0100, 1'b1, 4'b0100}   // R10 last 0 -> 2
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic [2:0]      cfg_sel;
    logic            cfg_mask;
    logic [3:0]      cfg_prio;
    logic            cfg_mode;
    logic [NCPU-1:0] cfg_dest;
    logic            pend_we;
    logic [2:0]      pend_sel;
    logic            pend_val;
    logic            eval_req;
    logic [2:0]      eval_sel;
    logic            acc_valid;
    logic [2:0]      acc_sel;
    logic [NSRC-1:0] eoi_clr;
    logic [NCPU-1:0] dlv_valid;
    logic [2:0]      dlv_src;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_route_top #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_mask  (cfg_mask),
        .cfg_prio  (cfg_prio),
        .cfg_mode  (cfg_mode),
        .cfg_dest  (cfg_dest),
        .pend_we   (pend_we),
        .pend_sel  (pend_sel),
        .pend_val  (pend_val),
        .eval_req  (eval_req),
        .eval_sel  (eval_sel),
        .acc_valid (acc_valid),
        .acc_sel   (acc_sel),
        .eoi_clr   (eoi_clr),
        .dlv_valid (dlv_valid),
        .dlv_src   (dlv_src)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int s, input bit m, input int p, input bit md, input int d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 3'(s);
        cfg_mask = m;
        cfg_prio = 4'(p);
        cfg_mode = md;
        cfg_dest = 4'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_pend(input int s, input bit v);
        @(negedge clk);
        pend_we  = 1'b1;
        pend_sel = 3'(s);
        pend_val = v;
        @(negedge clk);
        pend_we = 1'b0;
    endtask

    task automatic accept(input int s);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_sel   = 3'(s);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic end_irq(input int s);
        @(negedge clk);
        eoi_clr[s] = 1'b1;
        @(negedge clk);
        eoi_clr = '0;
    endtask

    // Evaluate source s; the strobe is registered, so it is visible on the
    // next negedge, and must be gone one cycle later.
    task automatic evaluate(input int s, input int exp, input string req);
        @(negedge clk);
        eval_req = 1'b1;
        eval_sel = 3'(s);
        @(negedge clk);
        eval_req = 1'b0;
        check(dlv_valid == 4'(exp), req, int'(dlv_valid), exp);
        if (exp != 0) begin
            check(dlv_src == 3'(s), "R2 source", int'(dlv_src), s);
        end
        @(negedge clk);
        check(dlv_valid == '0, "R2 pulse", int'(dlv_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_sel   = '0;
        cfg_mask  = 1'b0;
        cfg_prio  = '0;
        cfg_mode  = 1'b0;
        cfg_dest  = '0;
        pend_we   = 1'b0;
        pend_sel  = '0;
        pend_val  = 1'b0;
        eval_req  = 1'b0;
        eval_sel  = '0;
        acc_valid = 1'b0;
        acc_sel   = '0;
        eoi_clr   = '0;
        repeat (3) @(negedge clk);
        check(dlv_valid == '0, "R1 strobe", int'(dlv_valid), 0);
        rst_n = 1'b1;

        // R1: reset leaves a source masked with priority 0
        write_pend(2, 1'b1);
        evaluate(2, 0, "R1 reset config");

        // Table walk on source 3
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(3, VEC[i][14], int'(VEC[i][13:10]), VEC[i][9], int'(VEC[i][8:5]));
            write_pend(3, VEC[i][4]);
            evaluate(3, int'(VEC[i][3:0]), $sformatf("R3-R10 vector %0d", i));
        end

        // R6: activity set by accept, cleared by end-of-interrupt
        write_cfg(5, 1'b0, 7, 1'b0, 4'b0100);
        write_pend(5, 1'b1);
        evaluate(5, 4'b0100, "R6 before accept");
        accept(5);
        evaluate(5, 0, "R6 active");
        end_irq(5);
        evaluate(5, 4'b0100, "R6 after clear");
        // R6: accept and clear in the same cycle, set wins
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_sel    = 3'd5;
        eoi_clr[5] = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        eoi_clr   = '0;
        evaluate(5, 0, "R6 set wins");
        end_irq(5);
        evaluate(5, 4'b0100, "R6 cleared again");

        // R11: source 6 keeps its own last index (0), unaffected by source 3
        write_cfg(6, 1'b0, 3, 1'b1, 4'b1010);
        write_pend(6, 1'b1);
        evaluate(6, 4'b0010, "R11 independent index");

        // R12: eval and config write in the same cycle use the old state
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 3'd6;
        cfg_mask = 1'b1;
        cfg_prio = 4'd3;
        cfg_mode = 1'b1;
        cfg_dest = 4'b1010;
        eval_req = 1'b1;
        eval_sel = 3'd6;
        @(negedge clk);
        cfg_we   = 1'b0;
        eval_req = 1'b0;
        check(dlv_valid == 4'b1000, "R12 old state", int'(dlv_valid), 4'b1000);
        evaluate(6, 0, "R12 new state");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule